// File: doc/BRIEF.md
# Signed INT8 Outer-Product Accumulate Tile

This block keeps a 16 by 16 tile of 32-bit signed accumulators and grows it one step at a time. Each step delivers two 512-bit operand vectors. The left vector is a 16-row by 4-column slice of a left-hand matrix. The right vector is a 4-row by 16-column slice of a right-hand matrix. Every tile element adds a four-term signed dot product to its current value, widened to 32 bits. Stepping through the shared dimension one 4-wide slice at a time leaves the finished output submatrix in the tile.

The block has three ports. A clear input zeroes the whole tile. A valid/ready accumulate port accepts one step per clock and applies it to all 256 elements in that cycle. A readout port returns one requested row of 16 accumulators on the cycle after the request. A readout holds off accumulation, so the row leaving the block always matches a settled tile.

Top module: `opa_tile_top`

## Requirements
- R1: Operand byte 4·r+k sits at bits [32·r+8·k +: 8] of its vector. In the left vector, r is the tile row and k is the shared index. In the right vector, r is the tile column and k is the shared index.
- R2: Operand bytes are two's-complement signed. An accepted step adds sum over k=0..3 of L[i][k]·R[k][j] to element (i,j), so each element can change by any value from -65024 to +65536.
- R3: Accumulation wraps modulo 2^32 and never saturates.
- R4: A high clr_i zeroes all 256 elements at the next clock edge. If a step is offered in the same cycle, the clear wins and the step leaves no trace.
- R5: After reset, every element is zero, rd_valid_o is low and acc_ready_o is high.
- R6: acc_ready_o is low whenever rd_req_i or rd_valid_o is high. A step offered while acc_ready_o is low has no effect on the tile.
- R7: When rd_req_i is high with row index rd_row_i, rd_valid_o is high in the next cycle. In that cycle, bits [32·j +: 32] of rd_data_o hold element (rd_row_i, j) as it was before that clock edge.
- R8: In a cycle after no request, rd_valid_o is low and rd_data_o keeps its previous value.
- R9: Successive accepted steps add into the same tile. The tile holds the sum of all steps since the last clear or reset.
- R10: A step updates the whole tile at the clock edge that accepts it. A read requested in the very next cycle already returns the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Zero the whole tile |
| acc_valid_i | input | 1 | A step is offered on the operand inputs |
| acc_ready_o | output | 1 | The tile can take a step this cycle |
| a_vec_i | input | 512 | Left slice: 16 rows of 4 signed bytes |
| b_vec_i | input | 512 | Right slice: 16 columns of 4 signed bytes |
| rd_req_i | input | 1 | Request a row readout |
| rd_row_i | input | 4 | Row index to read |
| rd_valid_o | output | 1 | rd_data_o carries the requested row |
| rd_data_o | output | 512 | 16 accumulators of 32 bits, column j at bits 32·j |

## Verification
The in-design properties assume three things about the inputs. Reset is held for at least one edge. Operand inputs carry known values whenever a step is offered. A requester that wants its step applied keeps it offered until acc_ready_o is high. The stimulus respects these assumptions: every driver task changes inputs only on the falling clock edge, starts from known vectors, and waits on acc_ready_o before it counts a step as accepted. The exceptions are two deliberate collisions, a step offered together with a read request and a step offered together with a clear. For both, the expected tile is computed from the rule that the step is dropped.

// File: rtl/opa_pkg.sv
package opa_pkg;

    localparam int ROWS   = 16;
    localparam int COLS   = 16;
    localparam int KD     = 4;
    localparam int EW     = 8;
    localparam int AW     = 32;
    localparam int LANE_W = KD * EW;
    localparam int VEC_W  = ROWS * LANE_W;
    localparam int ROW_W  = COLS * AW;
    localparam int RIDX_W = $clog2(ROWS);
    localparam int PW     = 2 * EW;

    typedef logic signed [EW-1:0] elem_t;
    typedef elem_t [KD-1:0]       lane_t;
    typedef lane_t [ROWS-1:0]     lhs_vec_t;
    typedef lane_t [COLS-1:0]     rhs_vec_t;

    typedef logic [AW-1:0]        acc_t;
    typedef acc_t [COLS-1:0]      acc_row_t;
    typedef acc_row_t [ROWS-1:0]  acc_tile_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_STEP  = 2'd2
    } tile_cmd_e;

    function automatic acc_t widen_prod(input logic signed [PW-1:0] p);
        return {{(AW-PW){p[PW-1]}}, p};
    endfunction

endpackage

// File: rtl/opa_dot4.sv
module opa_dot4
    import opa_pkg::*;
(
    input  lane_t a_lane_i,
    input  lane_t b_lane_i,
    output acc_t  dot_o
);

    logic signed [PW-1:0] prod [KD];
    logic signed [AW-1:0] sum;

    for (genvar k = 0; k < KD; k++) begin : g_mul
        assign prod[k] = $signed(a_lane_i[k]) * $signed(b_lane_i[k]);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < KD; k++) begin
            sum = sum + $signed(widen_prod(prod[k]));
        end
    end

    assign dot_o = acc_t'(sum);

    // R2: four signed byte products never leave the expected range
    always_comb begin
        if (!$isunknown(sum)) begin
            p_dot_bound_r2: assert (sum <= 65536 && sum >= -65024);
        end
    end

endmodule

// File: rtl/opa_dot_grid.sv
module opa_dot_grid
    import opa_pkg::*;
(
    input  lhs_vec_t  lhs_i,
    input  rhs_vec_t  rhs_i,
    output acc_tile_t dots_o
);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            opa_dot4 u_dot (
                .a_lane_i (lhs_i[i]),
                .b_lane_i (rhs_i[j]),
                .dot_o    (dots_o[i][j])
            );
        end
    end

endmodule

// File: rtl/opa_tile_store.sv
module opa_tile_store
    import opa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tile_cmd_e cmd_i,
    input  acc_tile_t dots_i,
    output acc_tile_t tile_o
);

    always_ff @(posedge clk) begin
        if (rst || cmd_i == CMD_CLEAR) begin
            tile_o <= '0;
        end else if (cmd_i == CMD_STEP) begin
            for (int i = 0; i < ROWS; i++) begin
                for (int j = 0; j < COLS; j++) begin
                    tile_o[i][j] <= tile_o[i][j] + dots_i[i][j];
                end
            end
        end
    end

    // R4: a clear leaves every accumulator at zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_CLEAR) |=> (tile_o == '0));

    // R6: without a step or clear the tile does not move
    p_tile_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_IDLE) |=> $stable(tile_o));

endmodule

// File: rtl/opa_row_reader.sv
module opa_row_reader
    import opa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req_i,
    input  logic [RIDX_W-1:0] rd_row_i,
    input  acc_tile_t         tile_i,
    output logic              rd_valid_o,
    output logic [ROW_W-1:0]  rd_data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_req_i;
            if (rd_req_i) begin
                rd_data_o <= tile_i[rd_row_i];
            end
        end
    end

    // R7: a request is answered on the following cycle
    p_read_answer_r7: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> rd_valid_o);

    // R8: no request, no valid, and the data bus holds
    p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> (!rd_valid_o && $stable(rd_data_o)));

endmodule

// File: rtl/opa_tile_top.sv
module opa_tile_top
    import opa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              acc_valid_i,
    output logic              acc_ready_o,
    input  logic [VEC_W-1:0]  a_vec_i,
    input  logic [VEC_W-1:0]  b_vec_i,
    input  logic              rd_req_i,
    input  logic [RIDX_W-1:0] rd_row_i,
    output logic              rd_valid_o,
    output logic [ROW_W-1:0]  rd_data_o
);

    lhs_vec_t  lhs;
    rhs_vec_t  rhs;
    acc_tile_t dots;
    acc_tile_t tile;
    tile_cmd_e cmd;

    assign lhs = lhs_vec_t'(a_vec_i);
    assign rhs = rhs_vec_t'(b_vec_i);

    assign acc_ready_o = !(rd_req_i || rd_valid_o);

    always_comb begin
        if (clr_i) begin
            cmd = CMD_CLEAR;
        end else if (acc_valid_i && acc_ready_o) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_IDLE;
        end
    end

    opa_dot_grid u_grid (
        .lhs_i  (lhs),
        .rhs_i  (rhs),
        .dots_o (dots)
    );

    opa_tile_store u_store (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .dots_i (dots),
        .tile_o (tile)
    );

    opa_row_reader u_reader (
        .clk        (clk),
        .rst        (rst),
        .rd_req_i   (rd_req_i),
        .rd_row_i   (rd_row_i),
        .tile_i     (tile),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    // R6: a step is never applied while a readout is requested
    p_step_not_in_read_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |-> !rd_req_i);

    // R4: clear takes priority over an offered step
    p_clear_priority_r4: assert property (@(posedge clk) disable iff (rst)
        clr_i |-> (cmd == CMD_CLEAR));

endmodule

// File: tb/sim_opa_tile_top.sv
module sim_opa_tile_top;
    import opa_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr_i = 1'b0;
    logic              acc_valid_i = 1'b0;
    logic              acc_ready_o;
    logic [VEC_W-1:0]  a_vec_i = '0;
    logic [VEC_W-1:0]  b_vec_i = '0;
    logic              rd_req_i = 1'b0;
    logic [RIDX_W-1:0] rd_row_i = '0;
    logic              rd_valid_o;
    logic [ROW_W-1:0]  rd_data_o;

    int errors = 0;
    int checks = 0;

    logic [31:0]      mdl [ROWS][COLS];
    logic [ROW_W-1:0] exp_q [$];
    string            tag_q [$];
    int               row_q [$];
    logic [ROW_W-1:0] mon_exp;
    string            mon_tag;
    int               mon_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    opa_tile_top u0 (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (clr_i),
        .acc_valid_i (acc_valid_i),
        .acc_ready_o (acc_ready_o),
        .a_vec_i     (a_vec_i),
        .b_vec_i     (b_vec_i),
        .rd_req_i    (rd_req_i),
        .rd_row_i    (rd_row_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // scoreboard monitor: compare each returned row with the queued expectation
    always @(negedge clk) begin
        if (!rst && rd_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 stray rd_valid_o act=1 exp=0");
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                mon_row = row_q.pop_front();
                if (rd_data_o !== mon_exp) begin
                    errors++;
                    $display("FAIL %s row %0d act=%h exp=%h", mon_tag, mon_row, rd_data_o, mon_exp);
                end
            end
        end
    end

    function automatic logic [31:0] ref_dot(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                                            input int i, input int j);
        int s = 0;
        for (int k = 0; k < KD; k++) begin
            int x = int'($signed(a[(4*i+k)*8 +: 8]));
            int y = int'($signed(b[(4*j+k)*8 +: 8]));
            s += x * y;
        end
        return s;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                mdl[i][j] = '0;
    endtask

    task automatic model_step(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input int n);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                mdl[i][j] = mdl[i][j] + ref_dot(a, b, i, j) * n;
    endtask

    function automatic logic [ROW_W-1:0] model_row(input int r);
        logic [ROW_W-1:0] v;
        for (int j = 0; j < COLS; j++) v[32*j +: 32] = mdl[r][j];
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] rand_vec();
        logic [VEC_W-1:0] v;
        for (int w = 0; w < VEC_W/32; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] fill_vec(input logic [7:0] b);
        logic [VEC_W-1:0] v;
        for (int n = 0; n < VEC_W/8; n++) v[8*n +: 8] = b;
        return v;
    endfunction

    // all tasks start and end on a falling edge
    task automatic wait_ready();
        #1;
        while (!acc_ready_o) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_acc(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input int n);
        a_vec_i = a;
        b_vec_i = b;
        acc_valid_i = 1'b1;
        wait_ready();
        repeat (n) @(negedge clk);
        acc_valid_i = 1'b0;
        model_step(a, b, n);
    endtask

    task automatic do_read(input int r, input string tag);
        rd_req_i = 1'b1;
        rd_row_i = RIDX_W'(r);
        exp_q.push_back(model_row(r));
        tag_q.push_back(tag);
        row_q.push_back(r);
        #1;
        chk(acc_ready_o == 1'b0, "R6 ready during request", 64'(acc_ready_o), 64'd0);
        @(negedge clk);
        rd_req_i = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int r = 0; r < ROWS; r++) do_read(r, tag);
        #1;
        chk(acc_ready_o == 1'b0, "R6 ready while rd_valid_o", 64'(acc_ready_o), 64'd0);
        @(negedge clk);
    endtask

    task automatic do_clear();
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        model_clear();
    endtask

    initial begin
        logic [VEC_W-1:0] va;
        logic [VEC_W-1:0] vb;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R5: reset state at the ports
        chk(acc_ready_o == 1'b1, "R5 ready after reset", 64'(acc_ready_o), 64'd1);
        chk(rd_valid_o == 1'b0, "R5 valid after reset", 64'(rd_valid_o), 64'd0);
        @(negedge clk);
        read_all("R5 zero tile");

        // R1: sparse bytes land on exactly the elements they address
        va = '0; vb = '0;
        va[(4*2+1)*8 +: 8] = 8'd3;
        vb[(4*5+1)*8 +: 8] = 8'd7;
        va[(4*9+3)*8 +: 8] = 8'hFE;
        vb[(4*0+3)*8 +: 8] = 8'd5;
        do_acc(va, vb, 1);
        do_read(2, "R1 layout row 2");
        do_read(9, "R1 layout row 9");
        @(negedge clk);
        chk(mdl[2][5] == 32'd21 && mdl[9][0] == 32'hFFFF_FFF6, "R1 model sanity",
            {mdl[2][5], mdl[9][0]}, {32'd21, 32'hFFFF_FFF6});

        // R2: signed extremes
        do_clear();
        do_acc(fill_vec(8'h80), fill_vec(8'h80), 1);
        read_all("R2 min*min");
        do_clear();
        do_acc(fill_vec(8'h80), fill_vec(8'h7F), 1);
        read_all("R2 min*max");

        // R9 and R10: random steps build up, read right after the accepting edge
        do_clear();
        for (int s = 0; s < 6; s++) begin
            do_acc(rand_vec(), rand_vec(), 1);
            do_read(s % ROWS, "R10 read after step");
        end
        read_all("R9 accumulated random steps");

        // R6: a step offered alongside a read request is dropped
        va = rand_vec(); vb = rand_vec();
        rd_req_i = 1'b1; rd_row_i = 4'd3;
        exp_q.push_back(model_row(3)); tag_q.push_back("R7 row before blocked step"); row_q.push_back(3);
        a_vec_i = va; b_vec_i = vb; acc_valid_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0; acc_valid_i = 1'b0;
        @(negedge clk);
        read_all("R6 blocked step ignored");

        // R4: clear wins over a simultaneous step
        clr_i = 1'b1; acc_valid_i = 1'b1; a_vec_i = rand_vec(); b_vec_i = rand_vec();
        @(negedge clk);
        clr_i = 1'b0; acc_valid_i = 1'b0;
        model_clear();
        read_all("R4 clear priority");

        // R3: wrap past 2^31 and past 2^32
        do_acc(fill_vec(8'h80), fill_vec(8'h80), 32768);
        chk(mdl[0][0] == 32'h8000_0000, "R3 model sanity", 64'(mdl[0][0]), 64'h8000_0000);
        read_all("R3 wrap to negative");
        do_acc(fill_vec(8'h80), fill_vec(8'h80), 32769);
        read_all("R3 wrap past 2^32");

        // R8: idle cycles produce no stray valid (monitor flags any)
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all reads answered", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule